// File: doc/BRIEF.md
# Oversampling Serial Receiver with Three-Sample Voting

This block receives asynchronous serial frames on a single line. The line is sampled once on each clock cycle that carries an oversample enable pulse, and that pulse runs at sixteen times the bit rate. The line first passes through a flop synchronizer. The receiver finds the start bit and samples every bit sixteen times. A bit's value is the majority of three samples taken around the middle of the bit. Each finished frame is placed in a holding register, and a full flag tells the host that a frame is waiting.

A two-bit format field selects the frame shape:

- eight data bits with one stop bit;
- eight data bits with two stop bits;
- eight data bits plus a parity bit;
- nine data bits.

Four sticky flags report errors: noisy samples, a bad stop bit, a parity mismatch and a frame that arrived while the holding register was still full. Two host strobes control the outputs. A data read strobe frees the holding register. A status read strobe clears the four error flags.

The frame controller has six states:

- `RX_IDLE` watches for the start condition.
- `RX_START` re-checks the start bit at mid-bit.
- `RX_DATA` shifts in the data bits.
- `RX_PAR` checks the parity bit.
- `RX_STOP` checks the first stop bit.
- `RX_STOP2` checks the second stop bit.

The transitions between them are:

- IDLE→START: a low sample follows at least three high samples.
- START→IDLE: the start vote is high, which is a glitch.
- START→DATA: at the end of the start bit.
- DATA→PAR: after the last data bit, in the parity format.
- DATA→STOP: after the last data bit, in the other formats.
- PAR→STOP: at the end of the parity bit.
- STOP→STOP2: at the end of the first stop bit, in the two-stop format.
- STOP→IDLE and STOP2→IDLE: at the vote of the last stop bit, which completes the frame.
- Any state→IDLE: whenever the receiver is disabled.

Top module: `osr_uart_rx`

## Requirements
- R1: In idle, a low line sample starts a frame only when at least three consecutive high samples precede it; a low after fewer highs is ignored. Only cycles with `os_tick`=1 take samples. That first low sample is sample 1 of the start bit.
- R2: The start bit is re-checked with the vote of its samples 7, 8 and 9. If the majority is high, the receiver returns to idle: nothing is stored and no flag is set.
- R3: Every bit lasts 16 samples. Its value is the majority of its samples 7, 8 and 9, and data bits arrive least significant first.
- R4: If the three voting samples of any bit of an accepted frame disagree, `err_noise` is set and stays set. The frame is still received, using the majority values.
- R5: `fmt_mode` is latched at the start bit with this encoding: 00 = 8 data bits and 1 stop bit; 01 = 8 data bits and 2 stop bits; 10 = 8 data bits, a parity bit and 1 stop bit; 11 = 9 data bits and 1 stop bit.
- R6: In format 10, `par_even` (latched at the start bit) selects the parity sense: 0 means the total count of ones over the data and parity bits must be odd, and 1 means it must be even. A mismatch sets `err_parity`. `rx_bit9` returns the received parity bit.
- R7: In format 11, the ninth data bit is returned on `rx_bit9`. In formats 00 and 01, `rx_bit9` is 0.
- R8: A frame completes at sample 9 of its last stop bit. If `rx_full` is 0 at that point, the holding register loads `rx_data`/`rx_bit9` and `rx_full` becomes 1 on the next clock.
- R9: A one-cycle `rd_data_stb` clears `rx_full` on the next clock and leaves `rx_data` unchanged.
- R10: If a frame completes while `rx_full` is 1, `err_overrun` is set, the held data is kept and the new frame is discarded.
- R11: A stop bit that votes low sets `err_framing`. The frame is still stored.
- R12: A one-cycle `rd_stat_stb` clears all four error flags on the next clock. An error event in the same cycle wins over the clear.
- R13: While `rx_en` is 0, the receiver is held in idle and line traffic is ignored. The holding register and the flags keep their values.
- R14: After reset, `rx_full`, `rx_data`, `rx_bit9` and all four error flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| os_tick | input | 1 | Oversample enable, sixteen pulses per bit |
| rx_in | input | 1 | Asynchronous serial line, idle high |
| rx_en | input | 1 | Receiver enable |
| fmt_mode | input | 2 | Frame format select |
| par_even | input | 1 | Parity sense in parity format (1 = even) |
| rd_data_stb | input | 1 | Host read of the holding register; clears full |
| rd_stat_stb | input | 1 | Host read of the status; clears error flags |
| rx_data | output | DATA_W | Held data byte |
| rx_bit9 | output | 1 | Held ninth bit or parity bit |
| rx_full | output | 1 | Holding register occupied |
| err_noise | output | 1 | Sticky sample-disagreement flag |
| err_framing | output | 1 | Sticky bad-stop flag |
| err_parity | output | 1 | Sticky parity flag |
| err_overrun | output | 1 | Sticky overrun flag |

## Verification
The bench builds the block with its default parameters: 16 samples per bit, a vote on samples 7 to 9, 8-bit data, a three-sample idle qualifier and a two-flop synchronizer. It pulses `os_tick` on every second clock, so a full frame lasts about four hundred clocks. With those settings, every format, each error, an overrun and a rejected start glitch fit into one short run. The bench holds each line level for exactly one tick, so it can place a single-sample glitch on sample 8 of a chosen bit and place exactly two or three idle samples before a start edge.

// File: rtl/osr_rx_pkg.sv
package osr_rx_pkg;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP,
        RX_STOP2
    } rx_state_e;

    typedef enum logic [1:0] {
        FMT_8N1 = 2'b00,
        FMT_8N2 = 2'b01,
        FMT_8P1 = 2'b10,
        FMT_9N1 = 2'b11
    } rx_fmt_e;

    typedef struct packed {
        logic noise;
        logic framing;
        logic parity;
    } rx_evt_t;

endpackage

// File: rtl/osr_rx_sync.sv
module osr_rx_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[0] <= RST_VAL;
                else        chain[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[g] <= RST_VAL;
                else        chain[g] <= chain[g-1];
            end
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/osr_rx_vote.sv
module osr_rx_vote #(
    parameter int N = 3
) (
    input  logic [N-1:0] smp,
    output logic         maj,
    output logic         split
);

    localparam int CW = $clog2(N + 1);

    logic [CW-1:0] ones;

    always_comb begin
        ones = '0;
        for (int i = 0; i < N; i++) begin
            ones = ones + CW'(smp[i]);
        end
    end

    assign maj   = (ones > CW'(N / 2));
    assign split = (ones != '0) && (ones != CW'(N));

endmodule

// File: rtl/osr_rx_fsm.sv
module osr_rx_fsm
    import osr_rx_pkg::*;
#(
    parameter int OSR        = 16,
    parameter int VOTE_LO    = 7,
    parameter int VOTE_N     = 3,
    parameter int DATA_W     = 8,
    parameter int IDLE_HIGHS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rx_s,
    input  logic              rx_en,
    input  logic [1:0]        fmt_mode,
    input  logic              par_even,
    output logic              done,
    output logic [DATA_W:0]   frame_word,
    output rx_evt_t           evt,
    output logic              busy
);

    localparam int CNT_W   = $clog2(OSR + 1);
    localparam int HC_W    = $clog2(IDLE_HIGHS + 1);
    localparam int BIT_W   = $clog2(DATA_W + 2);
    localparam int VOTE_HI = VOTE_LO + VOTE_N - 1;

    rx_state_e         state, state_nx;
    logic [CNT_W-1:0]  scnt;
    logic [CNT_W-1:0]  nxt_cnt;
    logic [HC_W-1:0]   hcnt;
    logic [BIT_W-1:0]  bcnt;
    logic [BIT_W-1:0]  n_data;
    logic [VOTE_N-2:0] smp;
    logic [VOTE_N-1:0] vote_vec;
    logic [DATA_W:0]   shreg;
    rx_fmt_e           fmt_q;
    logic              pe_q;
    logic              par_q;
    logic              in_win, at_vote, at_end;
    logic              vote_maj, vote_split;
    logic              start_hit;

    assign nxt_cnt   = scnt + CNT_W'(1);
    assign in_win    = (nxt_cnt >= CNT_W'(VOTE_LO)) && (nxt_cnt <= CNT_W'(VOTE_HI));
    assign at_vote   = tick && (state != RX_IDLE) && (nxt_cnt == CNT_W'(VOTE_HI));
    assign at_end    = tick && (state != RX_IDLE) && (nxt_cnt == CNT_W'(OSR));
    assign vote_vec  = {smp, rx_s};
    assign n_data    = (fmt_q == FMT_9N1) ? BIT_W'(DATA_W + 1) : BIT_W'(DATA_W);
    assign start_hit = tick && !rx_s && (hcnt == HC_W'(IDLE_HIGHS));
    assign busy      = (state != RX_IDLE);

    osr_rx_vote #(.N(VOTE_N)) u_vote (
        .smp   (vote_vec),
        .maj   (vote_maj),
        .split (vote_split)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= state_nx;
    end

    // next state and per-cycle outputs
    always_comb begin
        state_nx = state;
        done     = 1'b0;
        evt      = '0;
        if (!rx_en) begin
            state_nx = RX_IDLE;
        end else begin
            unique case (state)
                RX_IDLE: begin
                    if (start_hit) state_nx = RX_START;
                end
                RX_START: begin
                    if (at_vote) begin
                        if (vote_maj) state_nx = RX_IDLE;
                        else          evt.noise = vote_split;
                    end else if (at_end) begin
                        state_nx = RX_DATA;
                    end
                end
                RX_DATA: begin
                    if (at_vote) evt.noise = vote_split;
                    if (at_end && (bcnt == n_data - BIT_W'(1))) begin
                        state_nx = (fmt_q == FMT_8P1) ? RX_PAR : RX_STOP;
                    end
                end
                RX_PAR: begin
                    if (at_vote) begin
                        evt.noise  = vote_split;
                        evt.parity = ((^shreg[DATA_W:1]) ^ vote_maj) == pe_q;
                    end
                    if (at_end) state_nx = RX_STOP;
                end
                RX_STOP: begin
                    if (at_vote) begin
                        evt.noise   = vote_split;
                        evt.framing = !vote_maj;
                        if (fmt_q != FMT_8N2) begin
                            done     = 1'b1;
                            state_nx = RX_IDLE;
                        end
                    end else if (at_end) begin
                        state_nx = RX_STOP2;
                    end
                end
                RX_STOP2: begin
                    if (at_vote) begin
                        evt.noise   = vote_split;
                        evt.framing = !vote_maj;
                        done        = 1'b1;
                        state_nx    = RX_IDLE;
                    end
                end
                default: state_nx = RX_IDLE;
            endcase
        end
    end

    // counters and shift datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scnt  <= '0;
            hcnt  <= '0;
            bcnt  <= '0;
            smp   <= '0;
            shreg <= '0;
            fmt_q <= FMT_8N1;
            pe_q  <= 1'b0;
            par_q <= 1'b0;
        end else if (!rx_en) begin
            scnt <= '0;
            hcnt <= '0;
            bcnt <= '0;
        end else if (tick) begin
            if (state == RX_IDLE) begin
                if (rx_s) begin
                    if (hcnt != HC_W'(IDLE_HIGHS)) hcnt <= hcnt + HC_W'(1);
                end else begin
                    hcnt <= '0;
                end
                if (start_hit) begin
                    scnt  <= CNT_W'(1);
                    bcnt  <= '0;
                    shreg <= '0;
                    fmt_q <= rx_fmt_e'(fmt_mode);
                    pe_q  <= par_even;
                end
            end else begin
                scnt <= at_end ? '0 : nxt_cnt;
                if (in_win) smp <= {smp[VOTE_N-3:0], rx_s};
                if (at_vote && (state == RX_DATA)) shreg <= {vote_maj, shreg[DATA_W:1]};
                if (at_vote && (state == RX_PAR))  par_q <= vote_maj;
                if (at_end && (state == RX_DATA))  bcnt  <= bcnt + BIT_W'(1);
            end
        end
    end

    always_comb begin
        unique case (fmt_q)
            FMT_9N1: frame_word = shreg;
            FMT_8P1: frame_word = {par_q, shreg[DATA_W:1]};
            default: frame_word = {1'b0, shreg[DATA_W:1]};
        endcase
    end

endmodule

// File: rtl/osr_rx_hold.sv
module osr_rx_hold
    import osr_rx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  logic [DATA_W:0]   frame_word,
    input  rx_evt_t           evt,
    input  logic              rd_data_stb,
    input  logic              rd_stat_stb,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_bit9,
    output logic              rx_full,
    output logic              err_noise,
    output logic              err_framing,
    output logic              err_parity,
    output logic              err_overrun
);

    logic load, ovr_ev;

    assign load   = done && !rx_full;
    assign ovr_ev = done && rx_full;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data <= '0;
            rx_bit9 <= 1'b0;
            rx_full <= 1'b0;
        end else begin
            if (load) begin
                rx_data <= frame_word[DATA_W-1:0];
                rx_bit9 <= frame_word[DATA_W];
                rx_full <= 1'b1;
            end else if (rd_data_stb) begin
                rx_full <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_noise   <= 1'b0;
            err_framing <= 1'b0;
            err_parity  <= 1'b0;
            err_overrun <= 1'b0;
        end else begin
            err_noise   <= (err_noise   && !rd_stat_stb) || evt.noise;
            err_framing <= (err_framing && !rd_stat_stb) || evt.framing;
            err_parity  <= (err_parity  && !rd_stat_stb) || evt.parity;
            err_overrun <= (err_overrun && !rd_stat_stb) || ovr_ev;
        end
    end

endmodule

// File: rtl/osr_uart_rx.sv
module osr_uart_rx
    import osr_rx_pkg::*;
#(
    parameter int OSR         = 16,
    parameter int VOTE_LO     = 7,
    parameter int VOTE_N      = 3,
    parameter int DATA_W      = 8,
    parameter int IDLE_HIGHS  = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              os_tick,
    input  logic              rx_in,
    input  logic              rx_en,
    input  logic [1:0]        fmt_mode,
    input  logic              par_even,
    input  logic              rd_data_stb,
    input  logic              rd_stat_stb,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_bit9,
    output logic              rx_full,
    output logic              err_noise,
    output logic              err_framing,
    output logic              err_parity,
    output logic              err_overrun
);

    logic            rx_s;
    logic            frame_done;
    logic            fsm_busy;
    logic            any_ev;
    logic [DATA_W:0] frame_word;
    rx_evt_t         evt;

    osr_rx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (rx_in),
        .q     (rx_s)
    );

    osr_rx_fsm #(
        .OSR        (OSR),
        .VOTE_LO    (VOTE_LO),
        .VOTE_N     (VOTE_N),
        .DATA_W     (DATA_W),
        .IDLE_HIGHS (IDLE_HIGHS)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (os_tick),
        .rx_s       (rx_s),
        .rx_en      (rx_en),
        .fmt_mode   (fmt_mode),
        .par_even   (par_even),
        .done       (frame_done),
        .frame_word (frame_word),
        .evt        (evt),
        .busy       (fsm_busy)
    );

    osr_rx_hold #(.DATA_W(DATA_W)) u_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .done        (frame_done),
        .frame_word  (frame_word),
        .evt         (evt),
        .rd_data_stb (rd_data_stb),
        .rd_stat_stb (rd_stat_stb),
        .rx_data     (rx_data),
        .rx_bit9     (rx_bit9),
        .rx_full     (rx_full),
        .err_noise   (err_noise),
        .err_framing (err_framing),
        .err_parity  (err_parity),
        .err_overrun (err_overrun)
    );

    assign any_ev = evt.noise || evt.framing || evt.parity || (frame_done && rx_full);

endmodule

// File: rtl/osr_uart_rx_chk.sv
module osr_uart_rx_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_en,
    input logic              rd_data_stb,
    input logic              rd_stat_stb,
    input logic [DATA_W-1:0] rx_data,
    input logic              rx_bit9,
    input logic              rx_full,
    input logic              err_noise,
    input logic              err_framing,
    input logic              err_parity,
    input logic              err_overrun,
    input logic              frame_done,
    input logic              fsm_busy,
    input logic              any_ev
);

    AST_FULL_NEEDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_full) |-> $past(frame_done)); // R8

    AST_READ_FREES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data_stb && !frame_done) |=> !rx_full); // R9

    AST_HOLD_STABLE_WHILE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        rx_full |=> ($stable(rx_data) && $stable(rx_bit9))); // R10

    AST_OVERRUN_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && rx_full) |=> err_overrun); // R10

    AST_STATUS_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stat_stb && !any_ev) |=> !(err_noise || err_framing || err_parity || err_overrun)); // R12

    AST_DISABLE_FORCES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !fsm_busy); // R13

endmodule

bind osr_uart_rx osr_uart_rx_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_en       (rx_en),
    .rd_data_stb (rd_data_stb),
    .rd_stat_stb (rd_stat_stb),
    .rx_data     (rx_data),
    .rx_bit9     (rx_bit9),
    .rx_full     (rx_full),
    .err_noise   (err_noise),
    .err_framing (err_framing),
    .err_parity  (err_parity),
    .err_overrun (err_overrun),
    .frame_done  (frame_done),
    .fsm_busy    (fsm_busy),
    .any_ev      (any_ev)
);

// File: tb/tb_osr_uart_rx.sv
`timescale 1ns/1ps
module tb_osr_uart_rx;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick = 1'b0;
    logic       rx_in = 1'b1;
    logic       rx_en = 1'b0;
    logic [1:0] fmt_mode = 2'b00;
    logic       par_even = 1'b0;
    logic       rd_data_stb = 1'b0;
    logic       rd_stat_stb = 1'b0;
    logic [7:0] rx_data;
    logic       rx_bit9, rx_full, err_noise, err_framing, err_parity, err_overrun;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    osr_uart_rx dut (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_in(rx_in), .rx_en(rx_en),
        .fmt_mode(fmt_mode), .par_even(par_even), .rd_data_stb(rd_data_stb),
        .rd_stat_stb(rd_stat_stb), .rx_data(rx_data), .rx_bit9(rx_bit9), .rx_full(rx_full),
        .err_noise(err_noise), .err_framing(err_framing), .err_parity(err_parity),
        .err_overrun(err_overrun)
    );

    always #2.5 clk = ~clk;

    // oversample pulse on every second clock
    initial begin
        forever begin
            @(negedge clk);
            os_tick = ~os_tick;
        end
    end

    // ---------------- behavioural reference model ----------------
    int m_s1 = 1, m_s2 = 1;
    int mst = 0, mcnt = 0, mh = 0, mfmt = 0, mpe = 0, mpar = 0;
    int mv[$];
    int mbits[$];
    int md = 0, mb9 = 0, mfull = 0, mn = 0, mf = 0, mp = 0, mo = 0;

    always @(posedge clk) begin
        int rs, ones, maj, split, evn, evf, evp, done, word, b9, nd, ovr;
        if (!rst_n) begin
            m_s1 = 1; m_s2 = 1; mst = 0; mcnt = 0; mh = 0;
            mv.delete(); mbits.delete();
            md = 0; mb9 = 0; mfull = 0; mn = 0; mf = 0; mp = 0; mo = 0;
        end else begin
            rs = m_s2; m_s2 = m_s1; m_s1 = int'(rx_in);
            evn = 0; evf = 0; evp = 0; done = 0; word = 0; b9 = 0;
            if (!rx_en) begin
                mst = 0; mh = 0; mcnt = 0; mv.delete();
            end else if (os_tick) begin
                if (mst == 0) begin
                    if (rs == 1) begin
                        if (mh < 3) mh++;
                    end else begin
                        if (mh == 3) begin
                            mst = 1; mcnt = 1; mfmt = int'(fmt_mode); mpe = int'(par_even);
                            mbits.delete(); mv.delete();
                        end
                        mh = 0;
                    end
                end else begin
                    mcnt++;
                    if (mcnt >= 7 && mcnt <= 9) mv.push_back(rs);
                    if (mcnt == 9) begin
                        ones = mv[0] + mv[1] + mv[2];
                        mv.delete();
                        maj = (ones >= 2) ? 1 : 0;
                        split = (ones == 1 || ones == 2) ? 1 : 0;
                        case (mst)
                            1: if (maj == 1) mst = 0; else evn = split;
                            2: begin evn = split; mbits.push_back(maj); end
                            3: begin
                                evn = split; mpar = maj; nd = 0;
                                foreach (mbits[i]) nd ^= mbits[i];
                                if (((nd ^ maj) == 1) != (mpe == 0)) evp = 1;
                            end
                            4: begin
                                evn = split; evf = 1 - maj;
                                if (mfmt != 1) begin done = 1; mst = 0; end
                            end
                            5: begin evn = split; evf = 1 - maj; done = 1; mst = 0; end
                            default: ;
                        endcase
                    end
                    if (mcnt == 16 && mst != 0) begin
                        mcnt = 0;
                        case (mst)
                            1: mst = 2;
                            2: if (mbits.size() == ((mfmt == 3) ? 9 : 8)) mst = (mfmt == 2) ? 3 : 4;
                            3: mst = 4;
                            4: mst = 5;
                            default: ;
                        endcase
                    end
                end
            end
            if (done == 1) begin
                for (int i = 0; i < 8; i++) word |= mbits[i] << i;
                if (mfmt == 3) b9 = mbits[8];
                else if (mfmt == 2) b9 = mpar;
            end
            ovr = (done == 1 && mfull == 1) ? 1 : 0;
            if (done == 1 && mfull == 0) begin
                md = word; mb9 = b9; mfull = 1;
            end else if (rd_data_stb) begin
                mfull = 0;
            end
            mn = ((mn == 1 && !rd_stat_stb) || evn == 1) ? 1 : 0;
            mf = ((mf == 1 && !rd_stat_stb) || evf == 1) ? 1 : 0;
            mp = ((mp == 1 && !rd_stat_stb) || evp == 1) ? 1 : 0;
            mo = ((mo == 1 && !rd_stat_stb) || ovr == 1) ? 1 : 0;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // every-clock comparison against the model
    always @(negedge clk) begin
        if (!finished) begin
            chk("R8 model rx_data",     int'(rx_data),     md);
            chk("R7 model rx_bit9",     int'(rx_bit9),     mb9);
            chk("R9 model rx_full",     int'(rx_full),     mfull);
            chk("R4 model err_noise",   int'(err_noise),   mn);
            chk("R11 model err_framing", int'(err_framing), mf);
            chk("R6 model err_parity",  int'(err_parity),  mp);
            chk("R10 model err_overrun", int'(err_overrun), mo);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic line(input bit lvl, input int nticks);
        rx_in = lvl;
        repeat (nticks * 2) @(negedge clk);
    endtask

    task automatic send_bit(input int lvl, input int gl);
        for (int s = 1; s <= 16; s++) begin
            rx_in = (s == gl) ? ~lvl[0] : lvl[0];
            repeat (2) @(negedge clk);
        end
    endtask

    task automatic send_frame(input int fmt, input int val, input int bad_par,
                              input int bad_stop, input int gl_bit, input int gl_smp);
        int bits[$];
        int n, p;
        fmt_mode = fmt[1:0];
        bits.push_back(0);
        n = (fmt == 3) ? 9 : 8;
        for (int i = 0; i < n; i++) bits.push_back((val >> i) & 1);
        if (fmt == 2) begin
            p = 0;
            for (int i = 0; i < 8; i++) p ^= (val >> i) & 1;
            if (!par_even) p = 1 - p;
            if (bad_par != 0) p = 1 - p;
            bits.push_back(p);
        end
        bits.push_back(1);
        if (fmt == 1) bits.push_back(1);
        if (bad_stop != 0) bits[bits.size() - 1] = 0;
        foreach (bits[k]) send_bit(bits[k], (k == gl_bit) ? gl_smp : 0);
        line(1'b1, 6);
    endtask

    task automatic read_data();
        rd_data_stb = 1'b1;
        @(negedge clk);
        rd_data_stb = 1'b0;
        @(negedge clk);
    endtask

    task automatic read_stat();
        rd_stat_stb = 1'b1;
        @(negedge clk);
        rd_stat_stb = 1'b0;
        @(negedge clk);
    endtask

    function automatic int flags();
        return {28'd0, err_noise, err_framing, err_parity, err_overrun};
    endfunction

    task automatic finish_run();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL R8 watchdog act=running exp=finished");
        finish_run();
    end

    // ---------------- directed sequence ----------------
    initial begin
        repeat (5) @(negedge clk);
        chk("R14 reset full", int'(rx_full), 0);
        chk("R14 reset data", int'(rx_data), 0);
        chk("R14 reset flags", flags(), 0);
        rst_n = 1'b1;
        @(negedge clk);
        rx_en = 1'b1;
        line(1'b1, 10);

        // format 00
        send_frame(0, 'hA5, 0, 0, -1, 0);
        chk("R3 data 8N1", int'(rx_data), 'hA5);
        chk("R8 full after frame", int'(rx_full), 1);
        chk("R7 bit9 zero in 8N1", int'(rx_bit9), 0);
        chk("R4 clean frame no noise", flags(), 0);
        read_data();
        chk("R9 full cleared", int'(rx_full), 0);
        chk("R9 data kept", int'(rx_data), 'hA5);

        // format 11, ninth bit
        send_frame(3, 'h13C, 0, 0, -1, 0);
        chk("R7 data 9N1", int'(rx_data), 'h3C);
        chk("R7 ninth bit", int'(rx_bit9), 1);
        read_data();

        // format 10, odd then even, then wrong parity
        par_even = 1'b0;
        send_frame(2, 'h5B, 0, 0, -1, 0);
        chk("R6 odd ok", int'(err_parity), 0);
        chk("R6 parity bit odd", int'(rx_bit9), 0);
        read_data();
        par_even = 1'b1;
        send_frame(2, 'h5B, 0, 0, -1, 0);
        chk("R6 even ok", int'(err_parity), 0);
        chk("R6 parity bit even", int'(rx_bit9), 1);
        read_data();
        send_frame(2, 'h0F, 1, 0, -1, 0);
        chk("R6 parity error", int'(err_parity), 1);
        chk("R5 data parity fmt", int'(rx_data), 'h0F);
        read_data();
        read_stat();
        chk("R12 flags cleared", flags(), 0);

        // format 01 with bad second stop
        send_frame(1, 'hC3, 0, 1, -1, 0);
        chk("R11 framing 2nd stop", int'(err_framing), 1);
        chk("R5 data 8N2", int'(rx_data), 'hC3);
        chk("R11 still stored", int'(rx_full), 1);
        read_data();
        read_stat();

        // format 00 bad stop
        send_frame(0, 'h81, 0, 1, -1, 0);
        chk("R11 framing 1 stop", int'(err_framing), 1);
        read_data();
        read_stat();

        // noise on sample 8 of data bit 3 (bit index 4 in the list)
        send_frame(0, 'h96, 0, 0, 4, 8);
        chk("R4 noise flag", int'(err_noise), 1);
        chk("R4 majority data", int'(rx_data), 'h96);
        chk("R3 no framing", int'(err_framing), 0);
        read_data();
        read_stat();

        // start glitch: five low samples then high
        line(1'b0, 5);
        line(1'b1, 30);
        chk("R2 glitch not stored", int'(rx_full), 0);
        chk("R2 glitch no flags", flags(), 0);

        // R1: too few idle highs, then exactly three
        rx_en = 1'b0;
        line(1'b0, 4);
        rx_en = 1'b1;
        line(1'b0, 20);
        line(1'b1, 2);
        line(1'b0, 20);
        chk("R1 two highs rejected", int'(rx_full), 0);
        chk("R1 no event", flags(), 0);
        line(1'b1, 3);
        send_frame(0, 'h3C, 0, 0, -1, 0);
        chk("R1 three highs accepted", int'(rx_full), 1);
        chk("R1 data", int'(rx_data), 'h3C);
        read_data();

        // overrun
        send_frame(0, 'h11, 0, 0, -1, 0);
        send_frame(0, 'h22, 0, 0, -1, 0);
        chk("R10 overrun flag", int'(err_overrun), 1);
        chk("R10 held data kept", int'(rx_data), 'h11);
        read_data();
        send_frame(0, 'h33, 0, 0, -1, 0);
        chk("R10 later frame", int'(rx_data), 'h33);
        read_data();
        read_stat();

        // disabled receiver
        rx_en = 1'b0;
        send_frame(0, 'h77, 0, 0, -1, 0);
        chk("R13 ignored full", int'(rx_full), 0);
        chk("R13 data unchanged", int'(rx_data), 'h33);
        chk("R13 flags unchanged", flags(), 0);
        rx_en = 1'b1;
        line(1'b1, 4);

        finish_run();
    end

endmodule